// File: doc/BRIEF.md
# Interrupt-Driven Single-Transfer Channels

This block gives a set of channels that each answer an interrupt trigger with one data move instead of a full interrupt service. Each channel holds a source pointer, a destination pointer and a control word. The control word carries a transfer count, a byte or word size and two increment enables. When a channel is triggered, the block reads one item at the source address and writes it at the destination address over a simple bus. It then steps the pointers that are enabled and counts the transfer down.

A channel whose count has run down to zero performs no transfer. Its next trigger goes out instead as a one-cycle normal interrupt pulse for that channel, and a sticky end-of-transfer flag tells software that the block of data is complete. A reserved count value marks a channel as continuous, so it moves data without ever counting. Triggers that arrive together are served one at a time, lowest channel first, and none is lost.

Top module: `evt_xfer_engine`

## Requirements
- R1: Each channel is configured on its own through the config port: `cfg_sel_i` 0 writes the source pointer, 1 writes the destination pointer, 2 writes the control word and 3 writes nothing. Control word bits [7:0] hold the count, bit 8 selects word size, bit 9 enables source increment and bit 10 enables destination increment.
- R2: A trigger on a channel whose count is not zero causes exactly one bus read at its source pointer, followed in the next cycle by one bus write at its destination pointer carrying the data that was read. The bus never reads and writes in the same cycle.
- R3: A byte channel drives `bus_word_o` low and moves only `bus_rdata_i[7:0]`, with the upper write bits zero. A word channel drives `bus_word_o` high and moves all 16 bits.
- R4: After a transfer, each pointer whose increment is enabled advances by 1 on a byte channel and by 2 on a word channel. A pointer whose increment is disabled stays unchanged.
- R5: Each transfer lowers the count of a non-continuous channel by one.
- R6: A count of FFh is continuous: transfers proceed without limit, the count stays FFh and the end flag is never set.
- R7: A trigger on a channel whose count is zero makes no bus access and produces a single one-cycle pulse on that channel's bit of `irq_o`.
- R8: The channel's `eof_o` bit is set by the transfer that brings its count to zero. It stays set until a 1 is written to that channel's `eof_clr_i` bit, and a set in the same cycle wins over a clear.
- R9: When several channels are pending, the lowest-numbered one is served first. The others stay pending and are all served later.
- R10: A trigger that arrives in the same cycle that its channel is granted stays pending and gives one more service. Further triggers that arrive while the channel is already pending merge into that one service.
- R11: After reset the bus is idle, `irq_o` is zero and every `eof_o` bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_ch_i | input | 3 | Channel addressed by the config write |
| cfg_sel_i | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfg_wdata_i | input | 16 | Config write data |
| trig_i | input | 8 | Per-channel trigger, sampled each cycle |
| eof_clr_i | input | 8 | Per-channel end-flag clear |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_addr_o | output | 16 | Bus byte address |
| bus_word_o | output | 1 | 1 for a 16-bit access, 0 for a byte access |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid in the read cycle |
| irq_o | output | 8 | One-cycle normal interrupt pulse per channel |
| eof_o | output | 8 | Sticky per-channel end-of-transfer flags |

## Verification
Trigger capture and grant can fall in the same cycle for one channel. The bench provokes this by holding a channel's trigger for three cycles, so that the second cycle lands on the grant and the third on the read. It then judges the result by counting bus writes: exactly two are expected, not one and not three. Triggers on two channels that arrive together are judged by the address of the first write.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CTL = 2'd2;
endpackage

// File: rtl/evt_pick.sv
module evt_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  oh_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        oh_o  = '0;
        idx_o = '0;
        any_o = |req_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                oh_o    = '0;
                oh_o[i] = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/evt_chan.sv
module evt_chan #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_src_i,
    input  logic          wr_dst_i,
    input  logic          wr_ctl_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          trig_i,
    input  logic          grant_i,
    input  logic          done_i,
    input  logic          clr_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [CW-1:0] cnt_o,
    output logic          word_o,
    output logic          pend_o,
    output logic          eof_o
);
    localparam logic [CW-1:0] CONT = '1;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          word;
        logic          inc_s;
        logic          inc_d;
        logic          pend;
        logic          eof;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [AW-1:0] step;

    always_comb begin
        ch_d = ch_q;
        step = ch_q.word ? AW'(2) : AW'(1);
        if (wr_src_i) ch_d.src = wdata_i;
        if (wr_dst_i) ch_d.dst = wdata_i;
        if (wr_ctl_i) begin
            ch_d.cnt   = wdata_i[CW-1:0];
            ch_d.word  = wdata_i[CW];
            ch_d.inc_s = wdata_i[CW+1];
            ch_d.inc_d = wdata_i[CW+2];
        end
        if (grant_i) ch_d.pend = 1'b0;
        if (trig_i)  ch_d.pend = 1'b1;
        if (clr_i)   ch_d.eof  = 1'b0;
        if (done_i) begin
            if (ch_q.inc_s) ch_d.src = ch_q.src + step;
            if (ch_q.inc_d) ch_d.dst = ch_q.dst + step;
            if (ch_q.cnt != CONT) begin
                ch_d.cnt = ch_q.cnt - 1'b1;
                if (ch_q.cnt == CW'(1)) ch_d.eof = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign src_o  = ch_q.src;
    assign dst_o  = ch_q.dst;
    assign cnt_o  = ch_q.cnt;
    assign word_o = ch_q.word;
    assign pend_o = ch_q.pend;
    assign eof_o  = ch_q.eof;

    // R8: the end flag holds until cleared
    p_eof_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.eof && !clr_i) |=> ch_q.eof);
    // R6: continuous count never moves
    p_cont_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.cnt == CONT && !wr_ctl_i) |=> ch_q.cnt == CONT);
    // R5: one step down per transfer
    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ch_q.cnt != CONT && !wr_ctl_i) |=> ch_q.cnt == $past(ch_q.cnt) - 1'b1);
    // R4: enabled source pointer steps by the item size
    p_src_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ch_q.inc_s && !wr_src_i && !wr_ctl_i)
        |=> ch_q.src == $past(ch_q.src) + ($past(ch_q.word) ? AW'(2) : AW'(1)));
    // R4: disabled destination pointer holds
    p_dst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ch_q.inc_d && !wr_dst_i) |=> $stable(ch_q.dst));
    // R10: a trigger is never dropped
    p_trig_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> ch_q.pend);
endmodule

// File: rtl/evt_xfer_engine.sv
module evt_xfer_engine
    import evt_xfer_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we_i,
    input  logic [CHW-1:0] cfg_ch_i,
    input  logic [1:0]     cfg_sel_i,
    input  logic [AW-1:0]  cfg_wdata_i,
    input  logic [NCH-1:0] trig_i,
    input  logic [NCH-1:0] eof_clr_i,
    output logic           bus_rd_o,
    output logic           bus_wr_o,
    output logic [AW-1:0]  bus_addr_o,
    output logic           bus_word_o,
    output logic [15:0]    bus_wdata_o,
    input  logic [15:0]    bus_rdata_i,
    output logic [NCH-1:0] irq_o,
    output logic [NCH-1:0] eof_o
);
    typedef struct packed {
        xfer_state_e    state;
        logic [CHW-1:0] ch;
        logic [15:0]    data;
        logic [NCH-1:0] irq;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [AW-1:0]  src_a  [NCH];
    logic [AW-1:0]  dst_a  [NCH];
    logic [CW-1:0]  cnt_a  [NCH];
    logic [NCH-1:0] word_v, pend_v, grant_v, done_v;
    logic [NCH-1:0] pick_oh;
    logic [CHW-1:0] pick_idx;
    logic           pick_any;

    evt_pick #(.N(NCH)) u_pick (
        .req_i (pend_v),
        .oh_o  (pick_oh),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic hit;
        assign hit = cfg_we_i && (cfg_ch_i == CHW'(g));
        evt_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_src_i (hit && cfg_sel_i == SEL_SRC),
            .wr_dst_i (hit && cfg_sel_i == SEL_DST),
            .wr_ctl_i (hit && cfg_sel_i == SEL_CTL),
            .wdata_i  (cfg_wdata_i),
            .trig_i   (trig_i[g]),
            .grant_i  (grant_v[g]),
            .done_i   (done_v[g]),
            .clr_i    (eof_clr_i[g]),
            .src_o    (src_a[g]),
            .dst_o    (dst_a[g]),
            .cnt_o    (cnt_a[g]),
            .word_o   (word_v[g]),
            .pend_o   (pend_v[g]),
            .eof_o    (eof_o[g])
        );
    end

    always_comb begin
        eng_d     = eng_q;
        eng_d.irq = '0;
        grant_v   = '0;
        done_v    = '0;
        case (eng_q.state)
            ST_IDLE: begin
                if (pick_any) begin
                    grant_v  = pick_oh;
                    eng_d.ch = pick_idx;
                    if (cnt_a[pick_idx] == '0) eng_d.irq   = pick_oh;
                    else                       eng_d.state = ST_READ;
                end
            end
            ST_READ: begin
                eng_d.data  = word_v[eng_q.ch] ? bus_rdata_i : {8'h00, bus_rdata_i[7:0]};
                eng_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                done_v[eng_q.ch] = 1'b1;
                eng_d.state      = ST_IDLE;
            end
            default: eng_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{state: ST_IDLE, ch: '0, data: '0, irq: '0};
        else        eng_q <= eng_d;
    end

    assign bus_rd_o    = (eng_q.state == ST_READ);
    assign bus_wr_o    = (eng_q.state == ST_WRITE);
    assign bus_addr_o  = bus_rd_o ? src_a[eng_q.ch] : dst_a[eng_q.ch];
    assign bus_word_o  = word_v[eng_q.ch];
    assign bus_wdata_o = eng_q.data;
    assign irq_o       = eng_q.irq;

    // R2: a read is always followed by a write
    p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_o |=> bus_wr_o);
    // R2: read and write never overlap
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_o && bus_wr_o));
    // R7: at most one interrupt pulse at a time
    p_irq_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
    // R7: an interrupt pulse comes with no bus access
    p_irq_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> (!bus_rd_o && !bus_wr_o));
    // R3: byte writes carry a zero upper half
    p_byte_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o && !bus_word_o) |-> bus_wdata_o[15:8] == 8'h00);
endmodule

// File: tb/evt_xfer_engine_test.sv
module evt_xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  trig = '0;
    logic [7:0]  eof_clr = '0;
    logic        bus_rd, bus_wr, bus_word;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [7:0]  irq, eof;

    logic [7:0]  mem [256];
    int          checks = 0;
    int          errors = 0;
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    int          irq_cnt = 0;
    logic [7:0]  irq_acc = '0;
    logic [15:0] first_wr = '0;

    always #10 clk = ~clk;

    evt_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
        .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .trig_i(trig),
        .eof_clr_i(eof_clr), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
        .bus_addr_o(bus_addr), .bus_word_o(bus_word), .bus_wdata_o(bus_wdata),
        .bus_rdata_i(bus_rdata), .irq_o(irq), .eof_o(eof)
    );

    function automatic logic [7:0] iv(int i);
        return 8'((i * 7 + 60) ^ 90);
    endfunction

    assign bus_rdata = {mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]};

    always @(posedge clk) begin
        if (bus_wr) begin
            if (wr_cnt == 0) first_wr <= bus_addr;
            wr_cnt <= wr_cnt + 1;
            mem[bus_addr[7:0]] <= bus_wdata[7:0];
            if (bus_word) mem[8'(bus_addr[7:0] + 8'd1)] <= bus_wdata[15:8];
        end
        if (bus_rd) rd_cnt <= rd_cnt + 1;
        if (|irq) begin
            irq_cnt <= irq_cnt + 1;
            irq_acc <= irq_acc | irq;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input int src, input int dst, input int ctl);
        cfg(ch, 0, src);
        cfg(ch, 1, dst);
        cfg(ch, 2, ctl);
    endtask

    task automatic fire(input logic [7:0] mask, input int hold);
        @(negedge clk);
        trig = mask;
        repeat (hold) @(negedge clk);
        trig = '0;
        repeat (12) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(negedge clk);
        wr_cnt = 0; rd_cnt = 0; irq_cnt = 0; irq_acc = '0;
    endtask

    task automatic t_reset();
        chk(!bus_rd && !bus_wr, "R11 bus idle", {bus_rd, bus_wr}, 0);
        chk(irq == 0, "R11 irq", irq, 0);
        chk(eof == 0, "R11 eof", eof, 0);
    endtask

    task automatic t_word_chain();
        setup(0, 16'h0010, 16'h0040, 16'h0703);
        clear_mon();
        for (int k = 0; k < 3; k++) fire(8'h01, 1);
        chk(wr_cnt == 3 && rd_cnt == 3, "R2 three transfers", wr_cnt, 3);
        for (int k = 0; k < 6; k++)
            chk(mem[8'h40 + k] == iv(16 + k), "R4 word dst step", mem[8'h40 + k], iv(16 + k));
        chk(eof[0] == 1'b1, "R8 eof on zero", eof[0], 1);
        chk(irq_cnt == 0, "R5 no irq before zero", irq_cnt, 0);
        clear_mon();
        fire(8'h01, 1);
        chk(wr_cnt == 0 && rd_cnt == 0, "R7 no bus at zero", wr_cnt + rd_cnt, 0);
        chk(irq_cnt == 1 && irq_acc == 8'h01, "R7 irq pulse", {irq_acc, 8'(irq_cnt)}, 16'h0101);
        chk(mem[8'h46] == iv(8'h46), "R7 dst untouched", mem[8'h46], iv(8'h46));
        repeat (3) @(negedge clk);
        chk(eof[0] == 1'b1, "R8 eof sticky", eof[0], 1);
        @(negedge clk); eof_clr = 8'h01;
        @(negedge clk); eof_clr = 8'h00;
        chk(eof[0] == 1'b0, "R8 eof cleared", eof[0], 0);
    endtask

    task automatic t_byte_src();
        setup(3, 16'h0020, 16'h0080, 16'h0202);
        cfg(3, 3, 16'h00C0);
        clear_mon();
        fire(8'h08, 1);
        chk(mem[8'h80] == iv(8'h20), "R3 byte moved", mem[8'h80], iv(8'h20));
        chk(mem[8'h81] == iv(8'h81), "R3 upper byte untouched", mem[8'h81], iv(8'h81));
        fire(8'h08, 1);
        chk(mem[8'h80] == iv(8'h21), "R4 src step 1 dst fixed", mem[8'h80], iv(8'h21));
        chk(first_wr == 16'h0080, "R1 sel 3 ignored", first_wr, 16'h0080);
        chk(eof[3] == 1'b1 && eof[0] == 1'b0, "R1 channels independent", eof, 8'h08);
    endtask

    task automatic t_continuous();
        setup(4, 16'h0030, 16'h0090, 16'h01FF);
        clear_mon();
        for (int k = 0; k < 4; k++) fire(8'h10, 1);
        chk(wr_cnt == 4, "R6 continuous transfers", wr_cnt, 4);
        chk(irq_cnt == 0 && eof[4] == 1'b0, "R6 no end", {irq_cnt[7:0], eof}, 0);
        chk({mem[8'h91], mem[8'h90]} == {iv(8'h31), iv(8'h30)}, "R4 no increment",
            {mem[8'h91], mem[8'h90]}, {iv(8'h31), iv(8'h30)});
    endtask

    task automatic t_priority();
        setup(5, 16'h0050, 16'h00A0, 16'h0001);
        setup(2, 16'h0051, 16'h00A8, 16'h0001);
        clear_mon();
        fire(8'h24, 1);
        chk(first_wr == 16'h00A8, "R9 lowest first", first_wr, 16'h00A8);
        chk(wr_cnt == 2, "R9 both served", wr_cnt, 2);
        chk(mem[8'hA0] == iv(8'h50) && mem[8'hA8] == iv(8'h51), "R9 data",
            {mem[8'hA0], mem[8'hA8]}, {iv(8'h50), iv(8'h51)});
    endtask

    task automatic t_retrigger();
        setup(6, 16'h0060, 16'h00B0, 16'h0405);
        clear_mon();
        fire(8'h40, 3);
        chk(wr_cnt == 2, "R10 grant-cycle trigger kept, later merged", wr_cnt, 2);
        chk(mem[8'hB0] == iv(8'h60) && mem[8'hB1] == iv(8'h60), "R10 dst step",
            {mem[8'hB0], mem[8'hB1]}, {iv(8'h60), iv(8'h60)});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = iv(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_word_chain();
        t_byte_src();
        t_continuous();
        t_priority();
        t_retrigger();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule